// File: doc/BRIEF.md
# Flash erase command sequencer

This block is the command front end of a NOR-style flash array. It watches write bus cycles (address, data byte, write enable) and recognises two erase sequences, both six writes long: an unlock pair, an erase-setup byte, a second unlock pair, and a final byte. That final byte selects either the whole chip or the sector that the write address falls in. A sector erase opens an acceptance window. Inside that window, single-byte follow-up writes add further sectors to a pending bitmask. Every write restarts the window. When the window lapses, the erase runs.

The erase engine is modelled as a countdown of a parameterised length per sector. It works through the mask from the lowest sector upward and skips protected sectors. While the block is busy, the ready output is low and a status byte reports progress. Once erasing has begun, the decoder accepts only a suspend command; a resume is accepted while suspended. A bypass mode is also provided. In this mode a program command is taken without the unlock prefix unless the secured region is enabled, and a two-write exit sequence leaves the mode.

Top module: `flash_erase_seq`

## Requirements
- R1: A chip erase is the six writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h. A sector erase is the same sequence with the last write replaced by 30h at any address. Command addresses are the low 11 address bits, and the sector index is the address bits above them.
- R2: Any write that does not match the next expected step of a sequence returns the decoder to idle, so a later final byte on its own has no effect and ready stays high.
- R3: A chip erase loads the sector mask with every sector whose protect bit is clear and drops ready in the cycle after the last write, without an acceptance window.
- R4: A sector erase sets that sector's mask bit, unless the sector is protected, and drops ready in the cycle after the last write.
- R5: While the window is open, each 30h write adds its sector, in any order. Any write restarts the window. The window expires WINDOW_CYC cycles after the last write, and a write in that final cycle is still accepted.
- R6: A 30h write that arrives after the window has expired is rejected and does not change the mask.
- R7: While erasing, every write other than B0h is ignored. B0h suspends the erase, which freezes the mask and sets status bit 0. While suspended, 30h resumes the erase.
- R8: The erase clears mask bits one at a time, lowest sector first, ERASE_CYC cycles each. Ready returns high in the cycle after the last bit is cleared.
- R9: When ready, status reads 80h. When busy, status bit 7 reads 0, bit 6 inverts after every status-read strobe, bit 0 shows suspend, and the other bits read 0.
- R10: A synchronous reset aborts any erase. It leaves ready high, the mask empty and bypass mode off.
- R11: AAh@555h, 55h@2AAh, 20h@555h enters bypass mode. In bypass mode, A0h followed by any write gives a one-cycle prog_ack unless secure_en is high. The writes 90h then 00h leave bypass mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per bus write |
| wr_addr | input | 11+log2(NUM_SECT) | Write address; the low 11 bits are the command address and the upper bits are the sector index |
| wr_data | input | 8 | Write data byte |
| rd_status | input | 1 | Status read strobe |
| protect | input | NUM_SECT | Per-sector protect bits |
| secure_en | input | 1 | Secured region enabled; blocks program in bypass mode |
| ready | output | 1 | High when idle in read mode, low while busy |
| status | output | 8 | Status byte |
| sect_mask | output | NUM_SECT | Sectors pending erase |
| bypass_on | output | 1 | Bypass mode active |
| prog_ack | output | 1 | One-cycle pulse for an accepted bypass program |

## Verification
The window restart and the window expiry can fall in the same cycle. This happens when a sector-add write is sampled on exactly the edge where the window timer reaches zero. The bench provokes this by counting WINDOW_CYC-1 cycles after a write before issuing the next one. It judges the result from the mask: the new sector must appear, and the erase must start only a full window later. A write one cycle past that point must leave the mask untouched. A suspend that lands while a sector countdown is still running is also exercised, and it must freeze the mask across several sector periods.

// File: rtl/fes_pkg.sv
package fes_pkg;
    localparam int CMD_AW = 11;

    localparam logic [CMD_AW-1:0] A_FIRST  = 11'h555;
    localparam logic [CMD_AW-1:0] A_SECOND = 11'h2AA;

    localparam logic [7:0] D_UNLOCK_A  = 8'hAA;
    localparam logic [7:0] D_UNLOCK_B  = 8'h55;
    localparam logic [7:0] D_SETUP     = 8'h80;
    localparam logic [7:0] D_CHIP      = 8'h10;
    localparam logic [7:0] D_SECTOR    = 8'h30;
    localparam logic [7:0] D_SUSPEND   = 8'hB0;
    localparam logic [7:0] D_BYP_ENTER = 8'h20;
    localparam logic [7:0] D_BYP_PROG  = 8'hA0;
    localparam logic [7:0] D_BYP_EXIT1 = 8'h90;
    localparam logic [7:0] D_BYP_EXIT2 = 8'h00;

    typedef enum logic [1:0] {PH_READ, PH_WINDOW, PH_ERASE, PH_SUSP} phase_e;

    typedef enum logic [2:0] {
        S_IDLE, S_U1, S_U2, S_SETUP, S_U3, S_U4, S_BPRG, S_BRST
    } dec_state_e;

    typedef struct packed {
        logic chip;
        logic sect;
        logic susp;
        logic resume;
    } cmd_t;

    function automatic logic is_unlock(input logic [CMD_AW-1:0] a,
                                       input logic [7:0] d,
                                       input logic second);
        return second ? (a == A_SECOND && d == D_UNLOCK_B)
                      : (a == A_FIRST  && d == D_UNLOCK_A);
    endfunction
endpackage

// File: rtl/fes_decoder.sv
module fes_decoder
    import fes_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CMD_AW-1:0] cmd_addr,
    input  logic [7:0]        wr_data,
    input  phase_e            phase,
    input  logic              secure_en,
    output cmd_t              cmd,
    output logic              bypass_on,
    output logic              prog_ack
);
    dec_state_e st_q, st_d;
    logic       byp_d, ack_d;

    always_comb begin
        cmd   = '0;
        st_d  = st_q;
        byp_d = bypass_on;
        ack_d = 1'b0;
        if (wr_en) begin
            unique case (phase)
                PH_ERASE:  cmd.susp   = (wr_data == D_SUSPEND);
                PH_SUSP:   cmd.resume = (wr_data == D_SECTOR);
                PH_WINDOW: cmd.sect   = (wr_data == D_SECTOR);
                default: begin
                    if (bypass_on) begin
                        unique case (st_q)
                            S_BPRG: begin
                                ack_d = !secure_en;
                                st_d  = S_IDLE;
                            end
                            S_BRST: begin
                                if (wr_data == D_BYP_EXIT2) byp_d = 1'b0;
                                st_d = S_IDLE;
                            end
                            default: begin
                                if (wr_data == D_BYP_PROG)       st_d = S_BPRG;
                                else if (wr_data == D_BYP_EXIT1) st_d = S_BRST;
                                else                             st_d = S_IDLE;
                            end
                        endcase
                    end else begin
                        st_d = S_IDLE;
                        unique case (st_q)
                            S_IDLE:  if (is_unlock(cmd_addr, wr_data, 1'b0)) st_d = S_U1;
                            S_U1:    if (is_unlock(cmd_addr, wr_data, 1'b1)) st_d = S_U2;
                            S_U2: begin
                                if (cmd_addr == A_FIRST && wr_data == D_SETUP)
                                    st_d = S_SETUP;
                                else if (cmd_addr == A_FIRST && wr_data == D_BYP_ENTER)
                                    byp_d = 1'b1;
                            end
                            S_SETUP: if (is_unlock(cmd_addr, wr_data, 1'b0)) st_d = S_U3;
                            S_U3:    if (is_unlock(cmd_addr, wr_data, 1'b1)) st_d = S_U4;
                            S_U4: begin
                                if (cmd_addr == A_FIRST && wr_data == D_CHIP) cmd.chip = 1'b1;
                                else if (wr_data == D_SECTOR)                 cmd.sect = 1'b1;
                            end
                            default: st_d = S_IDLE;
                        endcase
                    end
                end
            endcase
        end
        if (phase != PH_READ) st_d = S_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= S_IDLE;
            bypass_on <= 1'b0;
            prog_ack  <= 1'b0;
        end else begin
            st_q      <= st_d;
            bypass_on <= byp_d;
            prog_ack  <= ack_d;
        end
    end

    // R11: a program acknowledge needs a write in bypass mode with the secured region off
    assert_prog_gated_R11: assert property (@(posedge clk) disable iff (rst)
        prog_ack |-> $past(wr_en && !secure_en && bypass_on));
endmodule

// File: rtl/fes_window.sv
module fes_window #(
    parameter int WINDOW_CYC = 20000
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic active,
    output logic expire
);
    localparam int CNT_W = (WINDOW_CYC > 1) ? $clog2(WINDOW_CYC) : 1;
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(WINDOW_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                         cnt_q <= '0;
        else if (restart)                cnt_q <= LOAD;
        else if (active && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign expire = active && !restart && (cnt_q == '0);

    // R5: a restart always leaves at least one more cycle of window
    assert_restart_holds_R5: assert property (@(posedge clk) disable iff (rst)
        restart |=> !expire);
endmodule

// File: rtl/fes_engine.sv
module fes_engine
    import fes_pkg::*;
#(
    parameter int NUM_SECT  = 8,
    parameter int ERASE_CYC = 1000,
    localparam int SIDX_W   = $clog2(NUM_SECT)
) (
    input  logic                clk,
    input  logic                rst,
    input  cmd_t                cmd,
    input  logic [SIDX_W-1:0]   sect_idx,
    input  logic [NUM_SECT-1:0] protect,
    input  logic                expire,
    output phase_e              phase,
    output logic [NUM_SECT-1:0] mask
);
    localparam int ECNT_W = (ERASE_CYC > 1) ? $clog2(ERASE_CYC) : 1;
    localparam logic [ECNT_W-1:0] ELOAD = ECNT_W'(ERASE_CYC - 1);

    logic [ECNT_W-1:0]   ecnt_q;
    logic [NUM_SECT-1:0] sel, low, rest;

    assign sel  = NUM_SECT'(1) << sect_idx;
    assign low  = mask & (~mask + 1'b1);
    assign rest = mask & ~low;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_READ;
            mask   <= '0;
            ecnt_q <= '0;
        end else begin
            unique case (phase)
                PH_READ: begin
                    if (cmd.chip) begin
                        mask   <= ~protect;
                        ecnt_q <= ELOAD;
                        phase  <= PH_ERASE;
                    end else if (cmd.sect) begin
                        mask  <= sel & ~protect;
                        phase <= PH_WINDOW;
                    end
                end
                PH_WINDOW: begin
                    if (cmd.sect) mask <= mask | (sel & ~protect);
                    else if (expire) begin
                        ecnt_q <= ELOAD;
                        phase  <= PH_ERASE;
                    end
                end
                PH_ERASE: begin
                    if (cmd.susp)             phase <= PH_SUSP;
                    else if (mask == '0)      phase <= PH_READ;
                    else if (ecnt_q == '0) begin
                        mask   <= rest;
                        ecnt_q <= ELOAD;
                        if (rest == '0) phase <= PH_READ;
                    end else                  ecnt_q <= ecnt_q - 1'b1;
                end
                default: if (cmd.resume) phase <= PH_ERASE;
            endcase
        end
    end

    // R6: once the erase runs, no sector can join the mask
    assert_no_gain_R6: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_ERASE || phase == PH_SUSP) |=> ((mask & ~$past(mask)) == '0));

    // R3: chip erase never schedules a protected sector
    assert_protect_skip_R3: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_READ && cmd.chip) |=> ((mask & $past(protect)) == '0));

    // R7: suspended erase makes no progress
    assert_susp_freeze_R7: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SUSP && !cmd.resume) |=> $stable(mask));
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
    import fes_pkg::*;
#(
    parameter int NUM_SECT   = 8,
    parameter int WINDOW_CYC = 20000,
    parameter int ERASE_CYC  = 1000,
    localparam int SIDX_W    = $clog2(NUM_SECT),
    localparam int ADDR_W    = CMD_AW + SIDX_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [7:0]          wr_data,
    input  logic                rd_status,
    input  logic [NUM_SECT-1:0] protect,
    input  logic                secure_en,
    output logic                ready,
    output logic [7:0]          status,
    output logic [NUM_SECT-1:0] sect_mask,
    output logic                bypass_on,
    output logic                prog_ack
);
    cmd_t   cmd;
    phase_e phase;
    logic   expire, restart, tog_q, suspended;

    fes_decoder u_dec (
        .clk(clk), .rst(rst), .wr_en(wr_en),
        .cmd_addr(wr_addr[CMD_AW-1:0]), .wr_data(wr_data),
        .phase(phase), .secure_en(secure_en),
        .cmd(cmd), .bypass_on(bypass_on), .prog_ack(prog_ack)
    );

    assign restart = (phase == PH_READ && cmd.sect) || (phase == PH_WINDOW && wr_en);

    fes_window #(.WINDOW_CYC(WINDOW_CYC)) u_win (
        .clk(clk), .rst(rst), .restart(restart),
        .active(phase == PH_WINDOW), .expire(expire)
    );

    fes_engine #(.NUM_SECT(NUM_SECT), .ERASE_CYC(ERASE_CYC)) u_eng (
        .clk(clk), .rst(rst), .cmd(cmd),
        .sect_idx(wr_addr[ADDR_W-1:CMD_AW]), .protect(protect),
        .expire(expire), .phase(phase), .mask(sect_mask)
    );

    assign ready     = (phase == PH_READ);
    assign suspended = (phase == PH_SUSP);

    always_ff @(posedge clk) begin
        if (rst)                     tog_q <= 1'b0;
        else if (!ready && rd_status) tog_q <= ~tog_q;
    end

    assign status = ready ? 8'h80 : {1'b0, tog_q, 5'b0, suspended};

    // R7: while erasing, only the suspend byte can reach the suspended state
    assert_lockout_R7: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_ERASE && wr_en && wr_data != D_SUSPEND) |=> !suspended);

    // R9: each busy status read flips the toggle bit
    assert_toggle_R9: assert property (@(posedge clk) disable iff (rst)
        (!ready && rd_status) |=> (ready || status[6] != $past(status[6])));

    // R5: an expiring window hands over to the erase
    assert_expire_starts_R5: assert property (@(posedge clk) disable iff (rst)
        expire |=> (phase == PH_ERASE));

    // R10: reset leaves the block idle and empty
    assert_reset_idle_R10: assert property (@(posedge clk)
        rst |=> (ready && sect_mask == '0 && !bypass_on));
endmodule

// File: tb/flash_erase_seq_bench.sv
module flash_erase_seq_bench;
    localparam int NS  = 8;
    localparam int WIN = 16;
    localparam int ERS = 10;
    localparam int AW  = 11 + $clog2(NS);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic          rd_status = 1'b0;
    logic [NS-1:0] protect = '0;
    logic          secure_en = 1'b0;
    logic          ready, bypass_on, prog_ack;
    logic [7:0]    status;
    logic [NS-1:0] sect_mask;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    flash_erase_seq #(.NUM_SECT(NS), .WINDOW_CYC(WIN), .ERASE_CYC(ERS)) u_flash_erase_seq (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_status(rd_status), .protect(protect), .secure_en(secure_en),
        .ready(ready), .status(status), .sect_mask(sect_mask),
        .bypass_on(bypass_on), .prog_ack(prog_ack)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic unlock_pair();
        wr(AW'(11'h555), 8'hAA);
        wr(AW'(11'h2AA), 8'h55);
    endtask

    task automatic chip_seq();
        unlock_pair(); wr(AW'(11'h555), 8'h80);
        unlock_pair(); wr(AW'(11'h555), 8'h10);
    endtask

    task automatic sect_seq(input logic [AW-1:0] a);
        unlock_pair(); wr(AW'(11'h555), 8'h80);
        unlock_pair(); wr(a, 8'h30);
    endtask

    task automatic wait_ready(input int limit);
        for (int i = 0; i < limit && !ready; i++) @(negedge clk);
    endtask

    task automatic pulse_reset();
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset_state();
        check("R10 ready after reset", ready, 1);
        check("R10 mask after reset", sect_mask, 0);
        check("R10 bypass after reset", bypass_on, 0);
        check("R9 idle status", status, 8'h80);
    endtask

    task automatic t_mismatch();
        unlock_pair(); wr(AW'(11'h555), 8'h80);
        wr(AW'(11'h555), 8'hAA); wr(AW'(11'h2AA), 8'h77);
        wr(AW'(11'h555), 8'h10);
        check("R2 bad data aborts sequence", ready, 1);
        wr(AW'(11'h123), 8'hAA); wr(AW'(11'h2AA), 8'h55); wr(AW'(11'h555), 8'h80);
        unlock_pair(); wr(AW'(11'h555), 8'h10);
        check("R2 bad address aborts sequence", ready, 1);
        check("R2 mask untouched", sect_mask, 0);
    endtask

    task automatic t_chip_protect();
        logic t0;
        protect = 8'h24;
        chip_seq();
        check("R1 R3 chip erase busy", ready, 0);
        check("R3 protected sectors skipped", sect_mask, 8'hDB);
        check("R9 busy bit7", status[7], 0);
        t0 = status[6];
        rd_status = 1'b1; @(negedge clk); rd_status = 1'b0;
        check("R9 toggle flips", status[6], !t0);
        rd_status = 1'b1; @(negedge clk); rd_status = 1'b0;
        check("R9 toggle flips back", status[6], t0);
        wait_ready(200);
        check("R8 chip erase finishes", ready, 1);
        check("R8 mask empty after erase", sect_mask, 0);
        protect = '0;
    endtask

    task automatic t_sector_window();
        protect = 8'h08;
        sect_seq(AW'(14'h1000));
        check("R4 first sector in mask", sect_mask, 8'h04);
        check("R4 busy in window", ready, 0);
        repeat (5) @(negedge clk);
        wr(AW'(14'h2800), 8'h30);
        check("R5 second sector added", sect_mask, 8'h24);
        wr(AW'(14'h1800), 8'h30);
        check("R4 protected sector not added", sect_mask, 8'h24);
        repeat (WIN - 1) @(negedge clk);
        wr(AW'(14'h0000), 8'h30);
        check("R5 add on last window cycle", sect_mask, 8'h25);
        repeat (WIN) @(negedge clk);
        wr(AW'(14'h3800), 8'h30);
        check("R6 late add rejected", sect_mask, 8'h25);
        repeat (ERS - 2) @(negedge clk);
        check("R8 first sector still pending", sect_mask, 8'h25);
        @(negedge clk);
        check("R8 lowest sector first", sect_mask, 8'h24);
        repeat (ERS - 1) @(negedge clk);
        check("R8 second sector pending", sect_mask, 8'h24);
        @(negedge clk);
        check("R8 second sector cleared", sect_mask, 8'h20);
        repeat (ERS) @(negedge clk);
        check("R8 all sectors done", sect_mask, 0);
        check("R8 ready after erase", ready, 1);
        protect = '0;
    endtask

    task automatic t_lockout_suspend();
        sect_seq(AW'(14'h3000));
        repeat (WIN) @(negedge clk);
        chip_seq();
        check("R7 chip sequence ignored while erasing", sect_mask, 8'h40);
        check("R7 still erasing", status[0], 0);
        wr(AW'(14'h0000), 8'hB0);
        check("R7 suspend accepted", {status[7], status[0]}, 2'b01);
        repeat (3 * ERS) @(negedge clk);
        check("R7 suspend freezes mask", sect_mask, 8'h40);
        check("R7 suspend keeps busy", ready, 0);
        wr(AW'(14'h0000), 8'h30);
        check("R7 resume clears suspend", status[0], 0);
        wait_ready(100);
        check("R7 erase completes after resume", sect_mask, 0);
    endtask

    task automatic t_reset_abort();
        chip_seq();
        check("R3 full mask with no protection", sect_mask, 8'hFF);
        repeat (5) @(negedge clk);
        pulse_reset();
        check("R10 reset aborts erase", ready, 1);
        check("R10 reset clears mask", sect_mask, 0);
        sect_seq(AW'(14'h0800));
        check("R10 new sequence after reset", sect_mask, 8'h02);
        wait_ready(100);
        check("R10 erase after reset completes", ready, 1);
    endtask

    task automatic t_bypass();
        unlock_pair(); wr(AW'(11'h555), 8'h20);
        check("R11 bypass entered", bypass_on, 1);
        secure_en = 1'b0;
        wr(AW'(14'h0000), 8'hA0); wr(AW'(14'h1234), 8'h5A);
        check("R11 program acknowledged", prog_ack, 1);
        @(negedge clk);
        check("R11 acknowledge is one cycle", prog_ack, 0);
        secure_en = 1'b1;
        wr(AW'(14'h0000), 8'hA0); wr(AW'(14'h1234), 8'h5A);
        check("R11 program blocked by secured region", prog_ack, 0);
        secure_en = 1'b0;
        wr(AW'(14'h0000), 8'h90); wr(AW'(14'h0000), 8'h00);
        check("R11 bypass exited", bypass_on, 0);
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst = 1'b0;
        t_reset_state();
        t_mismatch();
        t_chip_protect();
        t_sector_window();
        t_lockout_suspend();
        t_reset_abort();
        t_bypass();
        summary();
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog all actual hung expected finished");
        summary();
        $finish;
    end
endmodule